// File: doc/BRIEF.md
# Dual-Channel High/Low-Count PWM Generator

This block drives two pulse-width-modulated outputs. Each channel's waveform is defined by two counts packed into one 32-bit word: the number of prescaled ticks the output spends high, and the number it spends low. Every channel has its own prescaler that divides a selected tick source by the programmed value plus one. A single shared control word holds, for both channels, the output enable, a delta-sigma enable, the clock-source select code, the prescaler value and the clock enable.

The block has one clock. Four tick-enable inputs stand in for the selectable clock sources, with code 0 being the crystal reference. A channel advances only on cycles where its selected source tick is high. Software reaches the registers through a simple word-addressed read/write port. The byte address is the word offset times four. Read data appears one cycle after the read strobe.

Changes to a running channel's counts are deferred to the next period boundary, so no phase is ever cut short. The two channels share the control word, but writing one channel's fields never disturbs the other channel's waveform.

Top module: `dual_pwm_gen`

## Requirements
- R1: After reset every register reads 0, `bus_rdata` is 0 and both outputs are low.
- R2: The duty word of channel 0 is at byte 0x00 and that of channel 1 at byte 0x04. Each holds the high count in bits [31:16] and the low count in bits [15:0], and reads back exactly what was written. Read data is valid on the cycle after `bus_re`.
- R3: The control word is at byte 0x08. Its bits hold, per channel:
  - output enable: bit 0 for channel 0, bit 1 for channel 1;
  - delta-sigma enable: bit 2 for channel 0, bit 3 for channel 1;
  - source select: [5:4] for channel 0, [7:6] for channel 1;
  - prescaler value: [14:8] for channel 0, [22:16] for channel 1;
  - clock enable: bit 15 for channel 0, bit 23 for channel 1.
  Bits [31:24] read as 0.
- R4: A running channel begins in its high phase. It is high for hi×(div+1) source ticks and then low for lo×(div+1) source ticks, repeating.
- R5: Source-select code k (0..3) makes the channel advance only on cycles where `src_tick[k]` is 1.
- R6: A channel runs only while both its output enable and its clock enable are 1. Otherwise its output is low and its counters return to the start of the high phase.
- R7: A set delta-sigma enable holds that channel's output low.
- R8: A high count of 0 gives a constant-low output. A low count of 0 with a nonzero high count gives a constant-high output. Both counts 0 give low.
- R9: A duty word written while the channel runs takes effect only at the next period boundary.
- R10: Writing one channel's duty word or control fields leaves the other channel's waveform unchanged.
- R11: Byte addresses 0x0C to 0x1C read as 0 and ignore writes.
- R12: An output changes only on the cycle after a prescaled tick of its channel, or when its run condition changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| src_tick | input | 4 | Tick enables of the four clock sources |
| pwm_out | output | 2 | Channel outputs, bit c for channel c |

## Verification
The following rules are checked by assertions on every cycle:
- a stopped channel stays low, and a delta-sigma enable forces its channel low;
- a stopped channel produces no prescaled ticks;
- unused addresses return zero;
- each output toggles only after a tick of its own prescaler or a change of its run condition.

The bench scenarios are what show the phase lengths for given counts and divide values, including the degenerate counts. They also show that new counts are deferred to the period boundary, that an idle source freezes the waveform, and that one channel's writes do not disturb the other channel's running waveform.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;
  localparam int NCH    = 2;
  localparam int NSRC   = 4;
  localparam int CNT_W  = 16;
  localparam int DIV_W  = 7;
  localparam int SEL_W  = $clog2(NSRC);
  localparam int DATA_W = 32;
  // control word: enables, ds bits, selects, then one byte per channel
  localparam int CTRL_W = 8 + 8 * NCH;

  typedef struct packed {
    logic             oe;
    logic             ds;
    logic             ce;
    logic [SEL_W-1:0] sel;
    logic [DIV_W-1:0] div;
    logic [CNT_W-1:0] hi;
    logic [CNT_W-1:0] lo;
  } chan_cfg_t;
endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_gen_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_we,
  input  logic                     bus_re,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  output chan_cfg_t [NCH-1:0]      cfg
);
  localparam int WORD_W = ADDR_W - 2;

  logic [DATA_W-1:0] duty_q [NCH];
  logic [CTRL_W-1:0] ctrl_q;
  logic [WORD_W-1:0] word;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_lsb;

  assign word       = bus_addr[ADDR_W-1:2];
  assign unused_lsb = ^bus_addr[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) duty_q[c] <= '0;
      ctrl_q <= '0;
    end else if (bus_we) begin
      for (int c = 0; c < NCH; c++)
        if (int'(word) == c) duty_q[c] <= bus_wdata;
      if (int'(word) == NCH) ctrl_q <= bus_wdata[CTRL_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NCH; c++)
      if (int'(word) == c) rd_mux = duty_q[c];
    if (int'(word) == NCH) rd_mux = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_fields
    assign cfg[c].oe  = ctrl_q[c];
    assign cfg[c].ds  = ctrl_q[NCH + c];
    assign cfg[c].sel = ctrl_q[2*NCH + SEL_W*c +: SEL_W];
    assign cfg[c].div = ctrl_q[8 + 8*c +: DIV_W];
    assign cfg[c].ce  = ctrl_q[8 + 8*c + DIV_W];
    assign cfg[c].hi  = duty_q[c][DATA_W-1 -: CNT_W];
    assign cfg[c].lo  = duty_q[c][CNT_W-1:0];
  end
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int DIV_W = 7,
  parameter int NSRC  = 4,
  localparam int SEL_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  input  logic [DIV_W-1:0] div,
  input  logic [NSRC-1:0]  src_tick,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic             src;
  logic             last;

  assign src  = src_tick[sel];
  assign last = (cnt == div);
  assign tick = run & src & last;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (src)       cnt <= last ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/pwm_phase_gen.sv
module pwm_phase_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] hi_in,
  input  logic [CNT_W-1:0] lo_in,
  output logic             pwm
);
  logic [CNT_W-1:0] act_hi, act_lo;
  logic [CNT_W:0]   pos, span;
  logic             wrap;

  assign span = {1'b0, act_hi} + {1'b0, act_lo};
  assign wrap = (span == '0) || (pos == span - 1'b1);
  assign pwm  = run && (act_hi != '0) && (pos < {1'b0, act_hi});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos    <= '0;
      act_hi <= '0;
      act_lo <= '0;
    end else if (!run) begin
      pos    <= '0;
      act_hi <= hi_in;
      act_lo <= lo_in;
    end else if (tick) begin
      if (wrap) begin
        pos    <= '0;
        act_hi <= hi_in;
        act_lo <= lo_in;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dual_pwm_gen.sv
module dual_pwm_gen
  import pwm_gen_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   src_tick,
  output logic [NCH-1:0]    pwm_out
);
  chan_cfg_t [NCH-1:0] cfg;
  logic [NCH-1:0]      run_vec;
  logic [NCH-1:0]      tick_vec;
  logic [NCH-1:0]      ds_vec;

  pwm_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg(cfg)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ds_vec[c]  = cfg[c].ds;
    assign run_vec[c] = cfg[c].oe & cfg[c].ce & ~cfg[c].ds;

    pwm_prescaler #(.DIV_W(DIV_W), .NSRC(NSRC)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(run_vec[c]), .sel(cfg[c].sel),
      .div(cfg[c].div), .src_tick(src_tick), .tick(tick_vec[c])
    );

    pwm_phase_gen #(.CNT_W(CNT_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .run(run_vec[c]), .tick(tick_vec[c]),
      .hi_in(cfg[c].hi), .lo_in(cfg[c].lo), .pwm(pwm_out[c])
    );
  end
endmodule

// File: rtl/pwm_gen_chk.sv
module pwm_gen_chk #(
  parameter int NCH    = 2,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_re,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NCH-1:0]    run_vec,
  input logic [NCH-1:0]    tick_vec,
  input logic [NCH-1:0]    ds_vec,
  input logic [NCH-1:0]    pwm_out
);
  logic hole_rd;
  assign hole_rd = bus_re && (int'(bus_addr[ADDR_W-1:2]) > NCH);

  // R11
  hole_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hole_rd) |-> bus_rdata == '0);

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R6
    stopped_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_vec[c] |-> !pwm_out[c]);
    // R7
    ds_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ds_vec[c] |-> !pwm_out[c]);
    // R6
    no_tick_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_vec[c] |-> !tick_vec[c]);
    // R12
    edge_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_out[c] != $past(pwm_out[c])) |->
        ($past(tick_vec[c]) || !$past(run_vec[c]) || !run_vec[c]));
  end
endmodule

bind dual_pwm_gen pwm_gen_chk #(
  .NCH(pwm_gen_pkg::NCH), .ADDR_W(ADDR_W), .DATA_W(pwm_gen_pkg::DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_re(bus_re), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .run_vec(run_vec), .tick_vec(tick_vec),
  .ds_vec(ds_vec), .pwm_out(pwm_out)
);

// File: tb/dual_pwm_gen_tb.sv
module dual_pwm_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  src_tick = 4'hF;
  logic [1:0]  pwm_out;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_pwm_gen u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_tick(src_tick), .pwm_out(pwm_out)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] ctl_a(int div, int sel, bit ds);
    return 32'h1 | (32'(ds) << 2) | (32'(sel) << 4) | (32'(div) << 8) | (32'h1 << 15);
  endfunction

  function automatic logic [31:0] ctl_b(int div, int sel, bit ds);
    return 32'h2 | (32'(ds) << 3) | (32'(sel) << 6) | (32'(div) << 16) | (32'h1 << 23);
  endfunction

  function automatic bit exp_out(int hi, int lo, int d, int i);
    int t;
    if (hi == 0 || hi + lo == 0) return 1'b0;
    t = (i / (d + 1)) % (hi + lo);
    return t < hi;
  endfunction

  // stop all, load one channel, start it; returns at sample 0
  task automatic start(input int ch, input int hi, input int lo, input int div,
                       input int sel, input bit ds);
    wr(5'h08, 32'h0);
    wr(5'(ch * 4), (32'(hi) << 16) | 32'(lo));
    wr(5'h08, ch == 0 ? ctl_a(div, sel, ds) : ctl_b(div, sel, ds));
  endtask

  task automatic watch(input int ch, input int hi, input int lo, input int div,
                       input int n, input string req);
    for (int i = 0; i < n; i++) begin
      chk(pwm_out[ch] == exp_out(hi, lo, div, i), req, pwm_out[ch], exp_out(hi, lo, div, i));
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk(pwm_out == 2'b00, "R1 outputs", pwm_out, 0);
    chk(bus_rdata == 0, "R1 rdata", bus_rdata, 0);
    for (int w = 0; w < 3; w++) begin
      rd(5'(w * 4), d);
      chk(d == 0, "R1 reg", d, 0);
    end
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(5'h00, 32'h1234_5678);
    wr(5'h04, 32'h9ABC_DEF0);
    rd(5'h00, d); chk(d == 32'h1234_5678, "R2 duty0", d, 32'h1234_5678);
    rd(5'h04, d); chk(d == 32'h9ABC_DEF0, "R2 duty1", d, 32'h9ABC_DEF0);
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h08, d); chk(d == 32'h00FF_FFFF, "R3 ctrl", d, 32'h00FF_FFFF);
    chk(pwm_out == 2'b00, "R7 ds low", pwm_out, 0);
    wr(5'h08, 32'h0);
  endtask

  task automatic t_waves();
    start(0, 3, 5, 0, 0, 0); watch(0, 3, 5, 0, 40, "R4 R12 ch0 div0");
    start(1, 2, 1, 2, 0, 0); watch(1, 2, 1, 2, 40, "R4 R12 ch1 div2");
    start(0, 1, 2, 4, 3, 0); watch(0, 1, 2, 4, 45, "R4 ch0 div4 sel3");
  endtask

  task automatic t_degenerate();
    start(0, 3, 0, 0, 0, 0); watch(0, 3, 0, 0, 16, "R8 lo=0 high");
    start(0, 0, 5, 0, 0, 0); watch(0, 0, 5, 0, 16, "R8 hi=0 low");
    start(1, 0, 0, 1, 0, 0); watch(1, 0, 0, 1, 16, "R8 both zero");
  endtask

  task automatic t_gating();
    wr(5'h08, 32'h0);
    wr(5'h00, (32'd2 << 16) | 32'd2);
    wr(5'h08, 32'h1);
    for (int i = 0; i < 10; i++) begin
      chk(pwm_out[0] == 1'b0, "R6 oe only", pwm_out[0], 0); @(negedge clk);
    end
    wr(5'h08, 32'h1 << 15);
    for (int i = 0; i < 10; i++) begin
      chk(pwm_out[0] == 1'b0, "R6 ce only", pwm_out[0], 0); @(negedge clk);
    end
    wr(5'h08, ctl_a(0, 0, 0));
    watch(0, 2, 2, 0, 7, "R6 run");
    wr(5'h08, 32'h0);
    wr(5'h08, ctl_a(0, 0, 0));
    watch(0, 2, 2, 0, 12, "R6 restart at high");
    start(0, 2, 2, 0, 0, 1);
    for (int i = 0; i < 10; i++) begin
      chk(pwm_out[0] == 1'b0, "R7 ds set", pwm_out[0], 0); @(negedge clk);
    end
  endtask

  task automatic t_source();
    src_tick = 4'b0100;
    start(0, 2, 3, 1, 2, 0); watch(0, 2, 3, 1, 30, "R5 sel2 ticking");
    start(0, 2, 2, 0, 1, 0);
    for (int i = 0; i < 12; i++) begin
      chk(pwm_out[0] == 1'b1, "R5 idle source frozen", pwm_out[0], 1); @(negedge clk);
    end
    src_tick = 4'hF;
  endtask

  task automatic t_boundary();
    start(0, 4, 4, 0, 0, 0);
    for (int i = 0; i < 30; i++) begin
      bit e;
      e = (i < 8) ? exp_out(4, 4, 0, i) : exp_out(2, 1, 0, i - 8);
      chk(pwm_out[0] == e, "R9 deferred update", pwm_out[0], e);
      if (i == 3) begin bus_we = 1'b1; bus_addr = 5'h00; bus_wdata = (32'd2 << 16) | 32'd1; end
      else bus_we = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_independent();
    logic [31:0] c0;
    wr(5'h08, 32'h0);
    wr(5'h00, (32'd3 << 16) | 32'd2);
    wr(5'h04, (32'd1 << 16) | 32'd1);
    c0 = ctl_a(1, 0, 0) | ctl_b(0, 0, 0);
    wr(5'h08, c0);
    for (int i = 0; i < 40; i++) begin
      chk(pwm_out[0] == exp_out(3, 2, 1, i), "R10 ch0 undisturbed", pwm_out[0], exp_out(3, 2, 1, i));
      if (i >= 13) chk(pwm_out[1] == 1'b0, "R10 ch1 ds now low", pwm_out[1], 0);
      if (i == 5)       begin bus_we = 1'b1; bus_addr = 5'h04; bus_wdata = (32'd7 << 16) | 32'd9; end
      else if (i == 12) begin bus_we = 1'b1; bus_addr = 5'h08; bus_wdata = c0 | (32'h1 << 3) | (32'd5 << 16); end
      else bus_we = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_holes();
    logic [31:0] d;
    wr(5'h08, 32'h0);
    wr(5'h00, 32'h0003_0004);
    for (int w = 3; w < 8; w++) wr(5'(w * 4), 32'hFFFF_FFFF);
    for (int w = 3; w < 8; w++) begin
      rd(5'(w * 4), d); chk(d == 0, "R11 hole reads zero", d, 0);
    end
    rd(5'h00, d); chk(d == 32'h0003_0004, "R11 duty0 untouched", d, 32'h0003_0004);
    rd(5'h08, d); chk(d == 0, "R11 ctrl untouched", d, 0);
    chk(pwm_out == 2'b00, "R11 outputs idle", pwm_out, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_waves();
    t_degenerate();
    t_gating();
    t_source();
    t_boundary();
    t_independent();
    t_holes();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule